// File: doc/BRIEF.md
# System Tick Down-Counter Timer

This block is a periodic tick timer for a processor subsystem. A 24-bit down-counter advances on each clock edge that sees the tick-enable input high, provided the timer is switched on. Three word-addressed registers sit on a simple register bus: a control word, a reload word and a live count word. When the counter sits at zero, the next tick loads the reload value and the count runs down again. The period is therefore the reload value plus one tick.

Each wrap from zero back to the reload value sets a sticky status bit. When interrupts are enabled, a wrap also sends out a one-cycle interrupt pulse. Reading the control word clears the status bit.

Two events give a silent reload. The first is switching the timer on. The second is any write to the count word, which forces the count to zero. In both cases the next tick loads the reload value and raises no status or interrupt. Software can therefore restart a period without causing a spurious wrap.

Top module: `tick_timer`

## Requirements
- R1: After reset, every register reads zero and `irq` is low.
- R2: While the ENABLE bit is 1, each clock edge with `tick_en` high lowers a nonzero count by exactly one. While ENABLE is 0, ticks leave the count unchanged.
- R3: A count of zero stays at zero for one full tick. The next tick loads the reload value, so the counter wraps with a period of reload+1 ticks.
- R4: When a write to the control word (word index 0) changes ENABLE (bit 0) from 0 to 1, the first tick after it loads the reload value, whatever the current count is. That load sets no status bit and sends no interrupt.
- R5: A write of any data to the count word (word index 2) sets the count to zero and clears the wrap flag. A tick on the same edge is overridden. The next tick performs a silent reload, as in R4.
- R6: The wrap flag (bit 16 of the control word) is set on each reload out of zero that was reached by counting down. A read of the control word returns the flag and clears it. If a wrap happens on the same edge as the read, the set wins.
- R7: When INTEN (bit 1 of the control word) is 1, each wrap raises `irq` for exactly one cycle, starting the cycle after the wrap edge. When INTEN is 0, `irq` stays low.
- R8: With a reload value of zero, a running counter stays at zero. It never sets the wrap flag and never raises `irq`.
- R9: The reload word is word index 1. Only its low 24 bits are stored, and bits 31:24 of every register read as zero. In the control word only bits 0, 1 and 16 can be nonzero. An unmapped word index (3 and above) reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick_en | input | 1 | Counting tick, sampled on each rising edge |
| bus_addr | input | 4 | Word index of the register accessed |
| bus_wr | input | 1 | Write strobe for the addressed register |
| bus_rd | input | 1 | Read strobe; enables the read side effect on the control word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | One-cycle interrupt pulse on each wrap |

## Verification
A wrong count shows up at the count word on the very next read. A wrong reload or a missing zero dwell moves the wrap by a tick or more. The bench catches this because it compares the count against an arithmetic model after a chosen number of ticks. A wrong silent-reload state shows as a flag or an `irq` pulse one tick after enabling or after a write to the count word. A stuck flag shows on the second back-to-back read of the control word.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  // word indices of the registers
  localparam int unsigned IDX_CTRL   = 0;
  localparam int unsigned IDX_RELOAD = 1;
  localparam int unsigned IDX_COUNT  = 2;

  // control word field positions
  localparam int unsigned BIT_ENABLE = 0;
  localparam int unsigned BIT_INTEN  = 1;
  localparam int unsigned BIT_FLAG   = 16;

  // default geometry
  localparam int unsigned DEF_DATA_W = 32;
  localparam int unsigned DEF_ADDR_W = 4;
  localparam int unsigned DEF_CNT_W  = 24;
endpackage

// File: rtl/tick_timer_regs.sv
module tick_timer_regs
  import tick_timer_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned CNT_W  = DEF_CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              flag_i,
  output logic [DATA_W-1:0] rdata,
  output logic              enable_o,
  output logic              inten_o,
  output logic [CNT_W-1:0]  reload_o,
  output logic              clr_o,
  output logic              arm_o,
  output logic              ctrl_rd_o
);
  localparam int unsigned PAD_W = DATA_W - CNT_W;

  logic             hit_ctrl, hit_reload, hit_count;
  logic             enable_q, inten_q;
  logic [CNT_W-1:0] reload_q;
  logic             unused_wdata;

  assign unused_wdata = ^wdata[DATA_W-1:CNT_W];

  // address decode
  assign hit_ctrl   = (addr == ADDR_W'(IDX_CTRL));
  assign hit_reload = (addr == ADDR_W'(IDX_RELOAD));
  assign hit_count  = (addr == ADDR_W'(IDX_COUNT));

  // named bus events
  assign clr_o     = wr_en & hit_count;
  assign arm_o     = wr_en & hit_ctrl & wdata[BIT_ENABLE] & ~enable_q;
  assign ctrl_rd_o = rd_en & hit_ctrl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable_q <= 1'b0;
      inten_q  <= 1'b0;
      reload_q <= '0;
    end else begin
      if (wr_en && hit_ctrl) begin
        enable_q <= wdata[BIT_ENABLE];
        inten_q  <= wdata[BIT_INTEN];
      end
      if (wr_en && hit_reload) reload_q <= wdata[CNT_W-1:0];
    end
  end

  function automatic logic [DATA_W-1:0] ctrl_view(input logic en, input logic ie,
                                                  input logic fl);
    logic [DATA_W-1:0] v;
    v = '0;
    v[BIT_ENABLE] = en;
    v[BIT_INTEN]  = ie;
    v[BIT_FLAG]   = fl;
    return v;
  endfunction

  function automatic logic [DATA_W-1:0] widen(input logic [CNT_W-1:0] v);
    return {{PAD_W{1'b0}}, v};
  endfunction

  always_comb begin
    rdata = '0;
    if (hit_ctrl)   rdata = ctrl_view(enable_q, inten_q, flag_i);
    if (hit_reload) rdata = widen(reload_q);
    if (hit_count)  rdata = widen(count_i);
  end

  assign enable_o = enable_q;
  assign inten_o  = inten_q;
  assign reload_o = reload_q;

  // R9: upper bits never carry data
  p_upper_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[DATA_W-1:CNT_W] == '0);
  // R4: a control write sets ENABLE from the data written
  p_enable_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_ctrl) |=> (enable_o == $past(wdata[BIT_ENABLE])));
  // R9: unmapped writes leave the reload word alone
  p_unmapped_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && hit_reload)) |=> $stable(reload_o));
endmodule

// File: rtl/tick_timer_counter.sv
module tick_timer_counter
  import tick_timer_pkg::*;
#(
  parameter int unsigned CNT_W = DEF_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             enable_i,
  input  logic [CNT_W-1:0] reload_i,
  input  logic             clr_i,
  input  logic             arm_i,
  output logic [CNT_W-1:0] count_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             silent_q, silent_d;
  logic             tick_go, at_zero;

  function automatic logic [CNT_W-1:0] step_down(input logic [CNT_W-1:0] v);
    return v - CNT_W'(1);
  endfunction

  assign tick_go = tick_i & enable_i;
  assign at_zero = (cnt_q == '0);

  always_comb begin
    cnt_d    = cnt_q;
    silent_d = silent_q;
    wrap_o   = 1'b0;
    if (clr_i) begin
      cnt_d    = '0;
      silent_d = 1'b1;
    end else if (arm_i) begin
      silent_d = 1'b1;
    end else if (tick_go) begin
      if (silent_q) begin
        cnt_d    = reload_i;
        silent_d = 1'b0;
      end else if (!at_zero) begin
        cnt_d = step_down(cnt_q);
      end else begin
        cnt_d  = reload_i;
        wrap_o = (reload_i != '0);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      silent_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      silent_q <= silent_d;
    end
  end

  assign count_o = cnt_q;

  // R2: decrement by one
  p_dec_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_go && !at_zero && !silent_q && !clr_i && !arm_i)
      |=> (count_o == CNT_W'($past(count_o) - 1'b1)));
  // R2: no movement while stopped
  p_hold_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable_i && !clr_i) |=> $stable(count_o));
  // R3: zero dwell then reload
  p_zero_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_go && at_zero && !clr_i && !arm_i) |=> (count_o == $past(reload_i)));
  // R4: silent reload raises no wrap
  p_silent_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    silent_q |-> !wrap_o);
  // R5: clear forces zero
  p_clear_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (count_o == '0));
  // R8: empty reload never wraps
  p_empty_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_i == '0) |-> !wrap_o);
endmodule

// File: rtl/tick_timer_status.sv
module tick_timer_status (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap_i,
  input  logic inten_i,
  input  logic ctrl_rd_i,
  input  logic clr_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q, irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (wrap_i)                 flag_q <= 1'b1;
      else if (ctrl_rd_i || clr_i) flag_q <= 1'b0;
      irq_q <= wrap_i & inten_i;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = irq_q;

  // R6: wrap sets the flag, even against a read
  p_flag_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_i |=> flag_o);
  // R6: read clears the flag
  p_flag_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctrl_rd_i || clr_i) && !wrap_i) |=> !flag_o);
  // R7: pulse lasts one cycle
  p_irq_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);
  // R7: pulse only with a fresh flag
  p_irq_with_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> flag_o);
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned ADDR_W = DEF_ADDR_W,
  parameter int unsigned CNT_W  = DEF_CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic [CNT_W-1:0] count_w, reload_w;
  logic             enable_w, inten_w, clr_w, arm_w, ctrl_rd_w;
  logic             wrap_w, flag_w;

  tick_timer_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr_en(bus_wr), .rd_en(bus_rd),
    .wdata(bus_wdata), .count_i(count_w), .flag_i(flag_w), .rdata(bus_rdata),
    .enable_o(enable_w), .inten_o(inten_w), .reload_o(reload_w),
    .clr_o(clr_w), .arm_o(arm_w), .ctrl_rd_o(ctrl_rd_w)
  );

  tick_timer_counter #(.CNT_W(CNT_W)) u_counter (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_en), .enable_i(enable_w),
    .reload_i(reload_w), .clr_i(clr_w), .arm_i(arm_w),
    .count_o(count_w), .wrap_o(wrap_w)
  );

  tick_timer_status u_status (
    .clk(clk), .rst_n(rst_n), .wrap_i(wrap_w), .inten_i(inten_w),
    .ctrl_rd_i(ctrl_rd_w), .clr_i(clr_w), .flag_o(flag_w), .irq_o(irq)
  );

  // R7: no interrupt while interrupts are masked and none pending
  p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!inten_w) |=> (!irq || $past(wrap_w)));
endmodule

// File: tb/tb_tick_timer.sv
module tb_tick_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  tick_timer dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  localparam logic [3:0] A_CTRL = 4'd0, A_RELOAD = 4'd1, A_COUNT = 4'd2;

  // {reload[47:24], ticks after enable[23:0]}
  localparam int NV = 10;
  localparam logic [47:0] VEC [NV] = '{
    {24'd5, 24'd0}, {24'd5, 24'd1}, {24'd5, 24'd4}, {24'd5, 24'd6},
    {24'd5, 24'd7}, {24'd5, 24'd13}, {24'd0, 24'd5}, {24'd1, 24'd3},
    {24'hFFFFFF, 24'd3}, {24'd2, 24'd9}
  };

  function automatic longint model_count(longint r, longint n);
    if (n == 0 || r == 0) return 0;
    return r - ((n - 1) % (r + 1));
  endfunction

  function automatic logic model_flag(longint r, longint n);
    if (n == 0 || r == 0) return 1'b0;
    return (n - 1) >= (r + 1);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk);
      tick_en = 1'b1;
      repeat (n) @(negedge clk);
      tick_en = 1'b0;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd(A_CTRL, v);   check("R1 ctrl", v, 32'h0);
    rd(A_RELOAD, v); check("R1 reload", v, 32'h0);
    rd(A_COUNT, v);  check("R1 count", v, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);

    // R9: upper bits, control field mask, unmapped index
    wr(A_RELOAD, 32'hFFFF_FFFF);
    rd(A_RELOAD, v); check("R9 reload mask", v, 32'h00FF_FFFF);
    wr(4'd3, 32'h0000_0011);
    rd(4'd3, v);     check("R9 unmapped read", v, 32'h0);
    rd(A_RELOAD, v); check("R9 unmapped write", v, 32'h00FF_FFFF);
    wr(A_CTRL, 32'hFFFE_FFFC);
    rd(A_CTRL, v);   check("R9 ctrl mask", v, 32'h0);

    // table: R2 R3 R4 R6 R8 against the arithmetic model
    for (int i = 0; i < NV; i++) begin
      longint r, n;
      r = longint'(VEC[i][47:24]);
      n = longint'(VEC[i][23:0]);
      wr(A_CTRL, 32'h0);
      wr(A_RELOAD, 32'(r));
      wr(A_COUNT, 32'h1234);
      wr(A_CTRL, 32'h1);
      ticks(int'(n));
      rd(A_COUNT, v); check("R3 table count", v, 32'(model_count(r, n)));
      rd(A_CTRL, v);  check("R6 table flag", {31'b0, v[16]}, {31'b0, model_flag(r, n)});
    end

    // R2: ticks while stopped do nothing
    wr(A_CTRL, 32'h0);
    wr(A_RELOAD, 32'd20);
    wr(A_COUNT, 32'h0);
    wr(A_CTRL, 32'h1);
    ticks(4);
    rd(A_COUNT, v); check("R2 running", v, 32'd17);
    wr(A_CTRL, 32'h0);
    ticks(5);
    rd(A_COUNT, v); check("R2 stopped", v, 32'd17);

    // R4: enable from a nonzero count reloads on the first tick
    wr(A_RELOAD, 32'd6);
    wr(A_CTRL, 32'h1);
    ticks(1);
    rd(A_COUNT, v); check("R4 reload on enable", v, 32'd6);
    rd(A_CTRL, v);  check("R4 no flag", {31'b0, v[16]}, 32'h0);

    // R5: count write while running clears, then silent reload
    ticks(2);
    wr(A_COUNT, 32'hABCD);
    rd(A_COUNT, v); check("R5 cleared", v, 32'h0);
    ticks(1);
    rd(A_COUNT, v); check("R5 silent reload", v, 32'd6);
    rd(A_CTRL, v);  check("R5 no flag", {31'b0, v[16]}, 32'h0);

    // R5: count write beats a tick on the same edge
    ticks(2);
    @(negedge clk);
    tick_en = 1'b1; bus_addr = A_COUNT; bus_wdata = 32'h7; bus_wr = 1'b1;
    @(negedge clk);
    tick_en = 1'b0; bus_wr = 1'b0;
    rd(A_COUNT, v); check("R5 write wins", v, 32'h0);

    // R5: count write clears a pending flag
    wr(A_CTRL, 32'h0);
    wr(A_RELOAD, 32'd1);
    wr(A_CTRL, 32'h1);
    ticks(3);  // reload 1, then 0, then wrap to 1
    wr(A_COUNT, 32'h0);
    rd(A_CTRL, v); check("R5 flag cleared", {31'b0, v[16]}, 32'h0);

    // R6: read clears; second read sees zero
    ticks(3);  // silent 1, 0, wrap
    rd(A_CTRL, v); check("R6 flag set", {31'b0, v[16]}, 32'h1);
    rd(A_CTRL, v); check("R6 flag cleared by read", {31'b0, v[16]}, 32'h0);

    // R6: wrap on the same edge as a control read keeps the flag
    ticks(1);  // count 1 -> 0
    @(negedge clk);
    tick_en = 1'b1; bus_addr = A_CTRL; bus_rd = 1'b1;
    #1 check("R6 pre-wrap read", {31'b0, bus_rdata[16]}, 32'h0);
    @(negedge clk);
    tick_en = 1'b0; bus_rd = 1'b0;
    rd(A_CTRL, v); check("R6 set wins", {31'b0, v[16]}, 32'h1);

    // R7: one-cycle irq pulse with INTEN
    wr(A_CTRL, 32'h0);
    wr(A_RELOAD, 32'd2);
    wr(A_CTRL, 32'h3);
    ticks(3);  // 2, 1, 0
    check("R7 idle before wrap", {31'b0, irq}, 32'h0);
    @(negedge clk); tick_en = 1'b1;
    @(negedge clk); tick_en = 1'b0;
    check("R7 pulse high", {31'b0, irq}, 32'h1);
    @(negedge clk);
    check("R7 pulse ends", {31'b0, irq}, 32'h0);

    // R7: masked interrupt
    wr(A_CTRL, 32'h0);
    wr(A_CTRL, 32'h1);
    ticks(3);  // 2, 1, 0
    @(negedge clk); tick_en = 1'b1;
    @(negedge clk); tick_en = 1'b0;
    check("R7 masked", {31'b0, irq}, 32'h0);
    rd(A_CTRL, v); check("R7 masked flag", {31'b0, v[16]}, 32'h1);

    // R8: zero reload never wraps, no irq
    wr(A_CTRL, 32'h0);
    wr(A_RELOAD, 32'd0);
    wr(A_CTRL, 32'h3);
    @(negedge clk); tick_en = 1'b1;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check("R8 no irq", {31'b0, irq}, 32'h0);
    end
    tick_en = 1'b0;
    rd(A_COUNT, v); check("R8 count zero", v, 32'h0);
    rd(A_CTRL, v);  check("R8 no flag", {31'b0, v[16]}, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule